// File: doc/BRIEF.md
# Parallel Multi-Bit CRC Remainder Engine

This block keeps the running remainder of a bit string divided modulo 2 by a fixed generator polynomial. It takes one data word of `W` bits per accepted transfer and performs `W` single-bit division steps in one clock. The most significant bit of the word goes first. The generator and the word width are fixed when the block is elaborated. Because the generator is a constant, the XOR network is built by unrolling a loop. No equation table is involved.

The input is a valid/ready stream. A word is consumed on a rising clock edge when `in_valid` and `in_ready` are both high. `in_ready` drops only while reset or a load is requested, and a word offered in such a cycle is not taken. The producer may hold `in_valid` low for any number of cycles to insert gaps. The remainder is kept and driven on `rem_out`, and the quotient is thrown away. The caller handles any zero augmentation, bit reflection or final inversion around the block.

The generator parameter holds the `DEG` low coefficients and leaves out the implicit leading 1. The remainder is `DEG` bits wide. Reset and load both preset it to a parameterized start value.

Top module: `crc_par_engine`

## Requirements
- R1: While `rst` is high at a rising edge, the remainder becomes `INIT` at that edge and `in_ready` stays low.
- R2: `load` high at an edge sets the remainder to `INIT`. This holds even when `in_valid` is high in the same cycle, and that word has no effect on the remainder.
- R3: With no word accepted and no load or reset, the remainder holds its value, whatever `in_data` carries.
- R4: An accepted word updates the remainder one edge later by `W` steps, taking `in_data[W-1]` first and `in_data[0]` last. Each step moves the current top remainder bit out, shifts the next data bit in at bit 0, and XORs `POLY` into the result if the bit moved out was 1.
- R5: `in_ready` is high exactly when neither `rst` nor `load` is high. A word is consumed only on an edge where `in_valid` and `in_ready` are both high.
- R6: Instances of widths 1, 2, 4 and 8 with the same generator and start value end with equal remainders after being given the same bit string, split into words MSB first.
- R7: With `DEG`=8, `POLY`=0x07 (x^8+x^2+x+1), `W`=8 and start value 0, the byte 0x80 followed by the byte 0x00 leaves remainder 0x89.
- R8: With `DEG`=32, `POLY`=0x04C11DB7, `W`=32 and start value 0, the word 0x00000001 leaves 0x00000001, and a following word 0x00000000 leaves 0x04C11DB7.
- R9: A 16-bit-per-clock instance with `POLY`=0x1021 and start value 0xFFFF follows the step rule of R4 on every accepted word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, presets remainder to `INIT` |
| load | input | 1 | Synchronous preset of the remainder to `INIT` |
| in_valid | input | 1 | Data word offered |
| in_ready | output | 1 | Block can accept a word this cycle |
| in_data | input | W | Data word, MSB processed first |
| rem_out | output | DEG | Current remainder |

## Verification
`rem_out` is the remainder register itself, so any wrong bit in the state appears at the port on the same edge that produced it. A wrong bit is never corrected by later data, because division is linear and the error carries into every later remainder. A behavioural model in the bench, updated on every edge, catches the first bad step within one cycle, and the fault stays visible until the next load or reset. The bench runs six widths side by side and uses hand-worked remainders for the 8- and 32-bit generators. These show ordering faults such as LSB-first stepping, a missing XOR term or a misplaced data bit. Such faults can look the same on all-zero data.

// File: rtl/crc_par_pkg.sv
package crc_par_pkg;

  // Next-state selection for the remainder register.
  typedef enum logic [1:0] {
    UPD_HOLD  = 2'd0,
    UPD_INIT  = 2'd1,
    UPD_SHIFT = 2'd2
  } crc_upd_e;

endpackage

// File: rtl/crc_par_ctrl.sv
module crc_par_ctrl
  import crc_par_pkg::*;
(
  input  logic     rst,
  input  logic     load,
  input  logic     in_valid,
  output logic     in_ready,
  output crc_upd_e upd
);

  // Preset (reset or load) wins over data; data moves only when offered.
  always_comb begin
    in_ready = 1'b1;
    upd      = UPD_HOLD;
    if (rst || load) begin
      in_ready = 1'b0;
      upd      = UPD_INIT;
    end else if (in_valid) begin
      upd      = UPD_SHIFT;
    end
  end

endmodule

// File: rtl/crc_div_step.sv
module crc_div_step #(
  parameter int unsigned     DEG  = 32,
  parameter logic [DEG-1:0]  POLY = '1
) (
  input  logic [DEG-1:0] rem_in,
  input  logic           bit_in,
  output logic [DEG-1:0] rem_out
);

  // One modulo-2 division step: append the data bit, then cancel the
  // bit leaving the top with the generator (implicit leading one).
  logic [DEG:0] widened;

  assign widened = {rem_in, bit_in};
  assign rem_out = widened[DEG-1:0] ^ (widened[DEG] ? POLY : '0);

endmodule

// File: rtl/crc_div_unroll.sv
module crc_div_unroll #(
  parameter int unsigned     DEG  = 32,
  parameter int unsigned     W    = 8,
  parameter logic [DEG-1:0]  POLY = '1
) (
  input  logic [DEG-1:0] rem_in,
  input  logic [W-1:0]   word,
  output logic [DEG-1:0] rem_out
);

  // Chain of W steps; stage i consumes word bit W-1-i (MSB first).
  for (genvar i = 0; i < W; i++) begin : g_step
    logic [DEG-1:0] src;
    logic [DEG-1:0] nxt;

    if (i == 0) begin : g_first
      assign src = rem_in;
    end else begin : g_next
      assign src = g_step[i-1].nxt;
    end

    crc_div_step #(
      .DEG  (DEG),
      .POLY (POLY)
    ) u_step (
      .rem_in  (src),
      .bit_in  (word[W-1-i]),
      .rem_out (nxt)
    );
  end

  assign rem_out = g_step[W-1].nxt;

endmodule

// File: rtl/crc_par_engine.sv
module crc_par_engine
  import crc_par_pkg::*;
#(
  parameter int unsigned     DEG  = 32,
  parameter int unsigned     W    = 8,
  parameter logic [DEG-1:0]  POLY = 32'h04C1_1DB7,
  parameter logic [DEG-1:0]  INIT = '1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [W-1:0]   in_data,
  output logic [DEG-1:0] rem_out
);

  crc_upd_e       upd;
  logic [DEG-1:0] rem_q;
  logic [DEG-1:0] rem_nxt;

  crc_par_ctrl u_ctrl (
    .rst      (rst),
    .load     (load),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .upd      (upd)
  );

  crc_div_unroll #(
    .DEG  (DEG),
    .W    (W),
    .POLY (POLY)
  ) u_unroll (
    .rem_in  (rem_q),
    .word    (in_data),
    .rem_out (rem_nxt)
  );

  always_ff @(posedge clk) begin
    case (upd)
      UPD_INIT:  rem_q <= INIT;
      UPD_SHIFT: rem_q <= rem_nxt;
      default:   rem_q <= rem_q;
    endcase
  end

  assign rem_out = rem_q;

  // ---------------------------------------------------------------
  // Assertions
  // ---------------------------------------------------------------
  logic rst_d_q;
  always_ff @(posedge clk) rst_d_q <= rst;

  always_ff @(posedge clk) begin
    if (rst_d_q) begin
      assert_init_after_reset_R1: assert (rem_q == INIT)
        else $error("remainder not at start value after reset");
    end
  end

  assert_load_presets_R2: assert property (@(posedge clk) disable iff (rst)
    load |=> (rem_q == INIT))
    else $error("load did not preset remainder");

  assert_idle_holds_R3: assert property (@(posedge clk) disable iff (rst)
    (!load && !in_valid) |=> $stable(rem_q))
    else $error("remainder moved without an accepted word");

  assert_zero_stays_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && (rem_q == '0) && (in_data == '0)) |=> (rem_q == '0))
    else $error("zero word on zero remainder gave nonzero");

  assert_refused_word_dropped_R5: assert property (@(posedge clk) disable iff (rst)
    !in_ready |=> (rem_q == INIT))
    else $error("word taken while not ready");

endmodule

// File: tb/crc_par_engine_tb.sv
module crc_par_engine_tb;

  logic clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic rst, load;
  logic v1, v2, v4, v8, v16, v32;
  logic [0:0]  d1;
  logic [1:0]  d2;
  logic [3:0]  d4;
  logic [7:0]  d8;
  logic [15:0] d16;
  logic [31:0] d32;
  logic rdy1, rdy2, rdy4, rdy8, rdy16, rdy32;
  logic [7:0]  r1, r2, r4, r8;
  logic [15:0] r16;
  logic [31:0] r32;

  crc_par_engine #(.DEG(8), .W(8), .POLY(8'h07), .INIT(8'h00)) u_dut (
    .clk(clk), .rst(rst), .load(load), .in_valid(v8), .in_ready(rdy8),
    .in_data(d8), .rem_out(r8));
  crc_par_engine #(.DEG(8), .W(1), .POLY(8'h07), .INIT(8'h00)) u_w1 (
    .clk(clk), .rst(rst), .load(load), .in_valid(v1), .in_ready(rdy1),
    .in_data(d1), .rem_out(r1));
  crc_par_engine #(.DEG(8), .W(2), .POLY(8'h07), .INIT(8'h00)) u_w2 (
    .clk(clk), .rst(rst), .load(load), .in_valid(v2), .in_ready(rdy2),
    .in_data(d2), .rem_out(r2));
  crc_par_engine #(.DEG(8), .W(4), .POLY(8'h07), .INIT(8'h00)) u_w4 (
    .clk(clk), .rst(rst), .load(load), .in_valid(v4), .in_ready(rdy4),
    .in_data(d4), .rem_out(r4));
  crc_par_engine #(.DEG(16), .W(16), .POLY(16'h1021), .INIT(16'hFFFF)) u_w16 (
    .clk(clk), .rst(rst), .load(load), .in_valid(v16), .in_ready(rdy16),
    .in_data(d16), .rem_out(r16));
  crc_par_engine #(.DEG(32), .W(32), .POLY(32'h04C11DB7), .INIT(32'h0)) u_w32 (
    .clk(clk), .rst(rst), .load(load), .in_valid(v32), .in_ready(rdy32),
    .in_data(d32), .rem_out(r32));

  int checks = 0;
  int errors = 0;
  logic run_cmp = 1'b0;
  logic done = 1'b0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // Behavioural long division, MSB first, quotient dropped.
  function automatic logic [63:0] divide(input logic [63:0] r, input logic [63:0] d,
                                         input int w, input int deg, input logic [63:0] poly);
    logic [63:0] mask;
    logic top;
    mask = (64'd1 << deg) - 64'd1;
    for (int i = w - 1; i >= 0; i--) begin
      top = r[deg-1];
      r = ((r << 1) | {63'd0, d[i]}) & mask;
      if (top) r = r ^ poly;
    end
    return r;
  endfunction

  logic [63:0] m1, m2, m4, m8, m16, m32;

  always @(posedge clk) begin
    if (rst || load) begin
      m1 <= 0; m2 <= 0; m4 <= 0; m8 <= 0; m16 <= 64'hFFFF; m32 <= 0;
    end else begin
      if (v1)  m1  <= divide(m1,  64'(d1),  1,  8,  64'h07);
      if (v2)  m2  <= divide(m2,  64'(d2),  2,  8,  64'h07);
      if (v4)  m4  <= divide(m4,  64'(d4),  4,  8,  64'h07);
      if (v8)  m8  <= divide(m8,  64'(d8),  8,  8,  64'h07);
      if (v16) m16 <= divide(m16, 64'(d16), 16, 16, 64'h1021);
      if (v32) m32 <= divide(m32, 64'(d32), 32, 32, 64'h04C11DB7);
    end
  end

  // Per-cycle comparison against the model, just after each edge.
  always @(posedge clk) begin
    #2;
    if (run_cmp) begin
      chk("R4 w8 remainder",  64'(r8),  m8);
      chk("R4 w1 remainder",  64'(r1),  m1);
      chk("R4 w2 remainder",  64'(r2),  m2);
      chk("R4 w4 remainder",  64'(r4),  m4);
      chk("R9 w16 remainder", 64'(r16), m16);
      chk("R8 w32 remainder", 64'(r32), m32);
      chk("R5 ready w8",  64'(rdy8),  64'(!(rst || load)));
      chk("R5 ready w32", 64'(rdy32), 64'(!(rst || load)));
    end
  end

  initial begin
    logic [31:0] msg;
    rst = 1'b1; load = 1'b0;
    v1 = 0; v2 = 0; v4 = 0; v8 = 0; v16 = 0; v32 = 0;
    d1 = 0; d2 = 0; d4 = 0; d8 = 0; d16 = 0; d32 = 0;
    @(negedge clk); @(negedge clk);
    chk("R1 reset w8",  64'(r8),  64'h00);
    chk("R1 reset w16", 64'(r16), 64'hFFFF);
    chk("R1 reset w32", 64'(r32), 64'h0);
    chk("R1 ready low in reset", 64'(rdy8), 64'd0);
    rst = 1'b0;
    run_cmp = 1'b1;

    // R7: header-check generator, two bytes.
    @(negedge clk); v8 = 1; d8 = 8'h80;
    @(negedge clk); d8 = 8'h00;
    @(negedge clk); v8 = 0;
    chk("R7 bytes 80 00", 64'(r8), 64'h89);

    // R3: data toggling without valid changes nothing.
    d8 = 8'hFF;
    @(negedge clk); d8 = 8'h3C;
    @(negedge clk); d8 = 8'hA7;
    @(negedge clk);
    chk("R3 hold while idle", 64'(r8), 64'h89);

    // R2: load with a word offered in the same cycle.
    load = 1; v8 = 1; d8 = 8'h5A;
    #1 chk("R2 ready low during load", 64'(rdy8), 64'd0);
    @(negedge clk);
    chk("R2 preset by load", 64'(r8), 64'h00);
    load = 0; v8 = 0;
    @(negedge clk);
    chk("R2 offered word dropped", 64'(r8), 64'h00);

    // R8: 32-bit generator, hand-worked values.
    v32 = 1; d32 = 32'h0000_0001;
    @(negedge clk);
    chk("R8 word 1", 64'(r32), 64'h0000_0001);
    d32 = 32'h0;
    @(negedge clk);
    chk("R8 word 0 after 1", 64'(r32), 64'h04C1_1DB7);
    v32 = 0;

    // R6: same bit string split into 1/2/4/8-bit words.
    load = 1;
    @(negedge clk); load = 0;
    msg = 32'hA5C3_1E77;
    for (int k = 0; k < 32; k++) begin
      v1 = 1; d1 = msg[31-k];
      v2 = (k < 16); if (k < 16) d2 = msg[31-2*k -: 2];
      v4 = (k < 8);  if (k < 8)  d4 = msg[31-4*k -: 4];
      v8 = (k < 4);  if (k < 4)  d8 = msg[31-8*k -: 8];
      @(negedge clk);
    end
    v1 = 0; v2 = 0; v4 = 0; v8 = 0;
    chk("R6 width 1 vs 8", 64'(r1), 64'(r8));
    chk("R6 width 2 vs 8", 64'(r2), 64'(r8));
    chk("R6 width 4 vs 8", 64'(r4), 64'(r8));
    chk("R6 width 8 vs model", 64'(r8),
        divide(64'h0, 64'(msg), 32, 8, 64'h07));

    // Random traffic with gaps and occasional loads on all widths.
    for (int i = 0; i < 300; i++) begin
      load = (i % 41 == 40);
      v1  = ($urandom % 4) != 0; d1  = 1'($urandom);
      v2  = ($urandom % 4) != 0; d2  = 2'($urandom);
      v4  = ($urandom % 4) != 0; d4  = 4'($urandom);
      v8  = ($urandom % 4) != 0; d8  = 8'($urandom);
      v16 = ($urandom % 4) != 0; d16 = 16'($urandom);
      v32 = ($urandom % 4) != 0; d32 = $urandom;
      @(negedge clk);
    end
    load = 0; v1 = 0; v2 = 0; v4 = 0; v8 = 0; v16 = 0; v32 = 0;
    @(negedge clk);
    run_cmp = 1'b0;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R4 watchdog act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule